// File: doc/BRIEF.md
# Exception Priority and Escalation Resolver

This block sits beside a processor core's exception entry logic. It collects every exception request source and builds a pending candidate for each valid exception number. Those sources are reset, the non-maskable interrupt, hard fault, three configurable fault classes, supervisor call, debug monitor, a software pend bit for the pendable service request, the periodic tick, and a parameterised bank of level-sensitive external interrupt lines. From those candidates it picks the single most urgent one. That number is always visible on `pendNum`. When the winner is strictly more urgent than the current execution level, the block enters it. The exception-number field and the handler flag are updated on the next clock edge, and a one-cycle preempt strobe is raised.

The current execution level is the more urgent of two values: the rank of the handler the block last entered (thread level when no handler is active), and an external masking rank supplied by the core. A configurable fault that is disabled, or that is not urgent enough to preempt that level, is not taken on its own. It is converted into a hard fault request instead. Exception numbers 7 to 10 and 13 have no source, so they can never appear.

Top module: `exc_resolver`

## Requirements
- R1: After reset `excNum` is 0, `handlerMode` is 0 and `preemptStrobe` is 0.
- R2: Exception numbers are fixed: reset 1, NMI 2, hard fault 3, memory fault 4, bus fault 5, usage fault 6, SVC 11, debug monitor 12, PendSV 14, SysTick 15, and external line i is 16+i. `pendNum` combinationally shows the number of the most urgent pending candidate, or 0 when nothing is pending. PendSV is pending only while `pendSvSet` is 1.
- R3: Urgency is ordered by rank; a lower rank wins, and on equal rank the lower exception number wins. Reset, NMI and hard fault have ranks 0, 1 and 2. A configurable priority p gives rank p+3. `sysPrio` lane k (bits 8k+7..8k at PRIO_W=8) holds the priority for: k=0 memory fault, 1 bus fault, 2 usage fault, 3 SVC, 4 debug monitor, 5 PendSV, 6 SysTick. `extPrio` lane i holds the priority of external line i.
- R4: The current level is the lower of the active handler's rank and `execRank`, which uses the same rank encoding. The active handler's rank is thread level 2^PRIO_W+3 (259 by default) when no handler is active. A winner preempts only if its rank is strictly below the current level.
- R5: On a clock edge where a preempting winner exists and `handlerExit` is 0, `excNum` takes the winner's number, `handlerMode` becomes 1, the active rank becomes the winner's rank, and `preemptStrobe` is 1 for the following cycle.
- R6: On a clock edge where `handlerExit` is 1, the block returns to thread mode: `excNum` is 0, `handlerMode` is 0, `preemptStrobe` is 0, even if a preempting winner exists that cycle. `excNum` is 0 whenever `handlerMode` is 0.
- R7: A memory, bus or usage fault request whose `faultEn` bit is 0 (bit 0 memory, bit 1 bus, bit 2 usage) is reported and taken as hard fault, number 3.
- R8: An enabled configurable fault whose rank is not strictly below the current level is reported and taken as hard fault; when its rank is below the current level it is reported under its own number.
- R9: NMI wins over every source except reset, and preempts any state other than an active reset or NMI handler, regardless of `execRank` values above 1.
- R10: The debug monitor is pending only while `dbgMonEn` is 1. When its rank is not strictly below the current level, it is reported but does not preempt.
- R11: Numbers 7, 8, 9, 10 and 13 never appear on `pendNum` or `excNum`.
- R12: An external line whose `extEnable` bit is 0 is never pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| resetReq | input | 1 | Reset exception request |
| nmiReq | input | 1 | Non-maskable interrupt request |
| hardFaultReq | input | 1 | Direct hard fault request |
| memFaultReq | input | 1 | Memory management fault request |
| busFaultReq | input | 1 | Bus fault request |
| usageFaultReq | input | 1 | Usage fault request |
| svcReq | input | 1 | Supervisor call request |
| dbgMonReq | input | 1 | Debug monitor request |
| pendSvSet | input | 1 | Software pend bit for the pendable service request |
| sysTickReq | input | 1 | Periodic tick request |
| extIrq | input | NUM_EXT | Level-sensitive external interrupt lines |
| faultEn | input | 3 | Enables for memory, bus and usage faults |
| dbgMonEn | input | 1 | Debug monitor enable |
| extEnable | input | NUM_EXT | Per-line external interrupt enables |
| sysPrio | input | 7*PRIO_W | Configurable system exception priorities |
| extPrio | input | NUM_EXT*PRIO_W | External line priorities |
| execRank | input | PRIO_W+2 | External masking rank on the current level |
| handlerExit | input | 1 | Return to thread mode |
| pendNum | output | clog2(16+NUM_EXT) | Number of the most urgent pending candidate |
| excNum | output | clog2(16+NUM_EXT) | Active exception number field |
| handlerMode | output | 1 | 1 in handler mode, 0 in thread mode |
| preemptStrobe | output | 1 | One-cycle pulse after an entry |

## Verification
The hardest situation to reach is escalation on insufficient priority. An enabled fault must arrive while a handler is already active, and that handler must be more urgent than the fault. So the stimulus first enters a high-priority external line, then raises a bus fault whose configured priority is weaker. It expects hard fault, and then repeats the same fault from thread mode, where it must keep its own number. NMI and reset precedence are reached by nesting: an external handler, then NMI under a strong `execRank` mask, then reset. The debug monitor is held off by a mask rank and then released by lifting the mask.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int EXC_RESET = 1;
  localparam int EXC_NMI = 2;
  localparam int EXC_HARD = 3;
  localparam int EXC_MEM = 4;
  localparam int EXC_BUS = 5;
  localparam int EXC_USAGE = 6;
  localparam int EXC_SVC = 11;
  localparam int EXC_DBGMON = 12;
  localparam int EXC_PENDSV = 14;
  localparam int EXC_TICK = 15;
  localparam int EXT_BASE = 16;

  // sysPrio lane indices
  localparam int LANE_MEM = 0;
  localparam int LANE_BUS = 1;
  localparam int LANE_USAGE = 2;
  localparam int LANE_SVC = 3;
  localparam int LANE_DBGMON = 4;
  localparam int LANE_PENDSV = 5;
  localparam int LANE_TICK = 6;
  localparam int SYS_LANES = 7;
  localparam int FAULT_KINDS = 3;
  localparam int FIXED_LEVELS = 3;

  typedef enum logic {MODE_THREAD = 1'b0, MODE_HANDLER = 1'b1} mode_e;

  typedef struct packed {
    logic loadWin;
    logic clearAct;
  } ctrl_t;
endpackage

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int NUM_EXT = 16,
  parameter int PRIO_W = 8,
  localparam int NUM_CAND = EXT_BASE + NUM_EXT,
  localparam int NUM_W = $clog2(NUM_CAND),
  localparam int RANK_W = PRIO_W + 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrl_t                       ctrl,
  input  logic                        resetReq,
  input  logic                        nmiReq,
  input  logic                        hardFaultReq,
  input  logic [FAULT_KINDS-1:0]      faultReq,
  input  logic [FAULT_KINDS-1:0]      faultEn,
  input  logic                        svcReq,
  input  logic                        dbgMonReq,
  input  logic                        dbgMonEn,
  input  logic                        pendSvSet,
  input  logic                        sysTickReq,
  input  logic [NUM_EXT-1:0]          extIrq,
  input  logic [NUM_EXT-1:0]          extEnable,
  input  logic [SYS_LANES*PRIO_W-1:0] sysPrio,
  input  logic [NUM_EXT*PRIO_W-1:0]   extPrio,
  input  logic [RANK_W-1:0]           execRank,
  output logic [NUM_W-1:0]            pendNum,
  output logic                        take,
  output logic [NUM_W-1:0]            excNum
);
  localparam logic [RANK_W-1:0] THREAD_RANK = RANK_W'((1 << PRIO_W) + FIXED_LEVELS);
  localparam logic [RANK_W-1:0] CFG_OFFSET = RANK_W'(FIXED_LEVELS);

  logic [RANK_W-1:0] activeRank;
  logic [RANK_W-1:0] curRank;
  logic [RANK_W-1:0] sysRank [SYS_LANES];
  logic [FAULT_KINDS-1:0] faultOk, faultTake, faultEsc;
  logic              candPend [NUM_CAND];
  logic [RANK_W-1:0] candRank [NUM_CAND];
  logic [NUM_W-1:0]  bestNum;
  logic [RANK_W-1:0] bestRank;
  logic              bestValid;

  // Current level: the more urgent of the active handler and the mask.
  assign curRank = (activeRank < execRank) ? activeRank : execRank;

  for (genvar s = 0; s < SYS_LANES; s++) begin : g_sysRank
    assign sysRank[s] = RANK_W'(sysPrio[s*PRIO_W +: PRIO_W]) + CFG_OFFSET;
  end

  // Configurable faults: taken on their own only when enabled and urgent enough.
  for (genvar f = 0; f < FAULT_KINDS; f++) begin : g_fault
    assign faultOk[f]   = faultEn[f] && (sysRank[LANE_MEM + f] < curRank);
    assign faultTake[f] = faultReq[f] && faultOk[f];
    assign faultEsc[f]  = faultReq[f] && !faultOk[f];
  end

  always_comb begin
    for (int i = 0; i < NUM_CAND; i++) begin
      candPend[i] = 1'b0;
      candRank[i] = THREAD_RANK;
    end
    candPend[EXC_RESET]  = resetReq;
    candRank[EXC_RESET]  = RANK_W'(0);
    candPend[EXC_NMI]    = nmiReq;
    candRank[EXC_NMI]    = RANK_W'(1);
    candPend[EXC_HARD]   = hardFaultReq || (|faultEsc);
    candRank[EXC_HARD]   = RANK_W'(2);
    candPend[EXC_MEM]    = faultTake[0];
    candRank[EXC_MEM]    = sysRank[LANE_MEM];
    candPend[EXC_BUS]    = faultTake[1];
    candRank[EXC_BUS]    = sysRank[LANE_BUS];
    candPend[EXC_USAGE]  = faultTake[2];
    candRank[EXC_USAGE]  = sysRank[LANE_USAGE];
    candPend[EXC_SVC]    = svcReq;
    candRank[EXC_SVC]    = sysRank[LANE_SVC];
    candPend[EXC_DBGMON] = dbgMonReq && dbgMonEn;
    candRank[EXC_DBGMON] = sysRank[LANE_DBGMON];
    candPend[EXC_PENDSV] = pendSvSet;
    candRank[EXC_PENDSV] = sysRank[LANE_PENDSV];
    candPend[EXC_TICK]   = sysTickReq;
    candRank[EXC_TICK]   = sysRank[LANE_TICK];
    for (int e = 0; e < NUM_EXT; e++) begin
      candPend[EXT_BASE + e] = extIrq[e] && extEnable[e];
      candRank[EXT_BASE + e] = RANK_W'(extPrio[e*PRIO_W +: PRIO_W]) + CFG_OFFSET;
    end
  end

  // Ascending scan with strict compare: equal rank keeps the lower number.
  always_comb begin
    bestNum   = '0;
    bestRank  = THREAD_RANK;
    bestValid = 1'b0;
    for (int i = 0; i < NUM_CAND; i++) begin
      if (candPend[i] && (!bestValid || (candRank[i] < bestRank))) begin
        bestNum   = NUM_W'(i);
        bestRank  = candRank[i];
        bestValid = 1'b1;
      end
    end
  end

  assign pendNum = bestNum;
  assign take    = bestValid && (bestRank < curRank);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excNum     <= '0;
      activeRank <= THREAD_RANK;
    end else if (ctrl.clearAct) begin
      excNum     <= '0;
      activeRank <= THREAD_RANK;
    end else if (ctrl.loadWin) begin
      excNum     <= bestNum;
      activeRank <= bestRank;
    end
  end
endmodule

// File: rtl/exc_control.sv
module exc_control
  import exc_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  take,
  input  logic  handlerExit,
  output ctrl_t ctrl,
  output logic  handlerMode,
  output logic  preemptStrobe
);
  mode_e modeQ;

  // Exit has precedence over a same-cycle entry.
  always_comb begin
    ctrl.clearAct = handlerExit;
    ctrl.loadWin  = take && !handlerExit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ         <= MODE_THREAD;
      preemptStrobe <= 1'b0;
    end else begin
      preemptStrobe <= ctrl.loadWin;
      if (ctrl.clearAct) begin
        modeQ <= MODE_THREAD;
      end else if (ctrl.loadWin) begin
        modeQ <= MODE_HANDLER;
      end
    end
  end

  assign handlerMode = (modeQ == MODE_HANDLER);
endmodule

// File: rtl/exc_resolver.sv
module exc_resolver
  import exc_pkg::*;
#(
  parameter int NUM_EXT = 16,
  parameter int PRIO_W = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              resetReq,
  input  logic                              nmiReq,
  input  logic                              hardFaultReq,
  input  logic                              memFaultReq,
  input  logic                              busFaultReq,
  input  logic                              usageFaultReq,
  input  logic                              svcReq,
  input  logic                              dbgMonReq,
  input  logic                              pendSvSet,
  input  logic                              sysTickReq,
  input  logic [NUM_EXT-1:0]                extIrq,
  input  logic [2:0]                        faultEn,
  input  logic                              dbgMonEn,
  input  logic [NUM_EXT-1:0]                extEnable,
  input  logic [7*PRIO_W-1:0]               sysPrio,
  input  logic [NUM_EXT*PRIO_W-1:0]         extPrio,
  input  logic [PRIO_W+1:0]                 execRank,
  input  logic                              handlerExit,
  output logic [$clog2(16+NUM_EXT)-1:0]     pendNum,
  output logic [$clog2(16+NUM_EXT)-1:0]     excNum,
  output logic                              handlerMode,
  output logic                              preemptStrobe
);
  ctrl_t ctrl;
  logic  take;

  exc_datapath #(.NUM_EXT(NUM_EXT), .PRIO_W(PRIO_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .resetReq     (resetReq),
    .nmiReq       (nmiReq),
    .hardFaultReq (hardFaultReq),
    .faultReq     ({usageFaultReq, busFaultReq, memFaultReq}),
    .faultEn      (faultEn),
    .svcReq       (svcReq),
    .dbgMonReq    (dbgMonReq),
    .dbgMonEn     (dbgMonEn),
    .pendSvSet    (pendSvSet),
    .sysTickReq   (sysTickReq),
    .extIrq       (extIrq),
    .extEnable    (extEnable),
    .sysPrio      (sysPrio),
    .extPrio      (extPrio),
    .execRank     (execRank),
    .pendNum      (pendNum),
    .take         (take),
    .excNum       (excNum)
  );

  exc_control u_ctl (
    .clk           (clk),
    .rstN          (rstN),
    .take          (take),
    .handlerExit   (handlerExit),
    .ctrl          (ctrl),
    .handlerMode   (handlerMode),
    .preemptStrobe (preemptStrobe)
  );
endmodule

// File: rtl/exc_resolver_chk.sv
module exc_resolver_chk #(
  parameter int NUM_EXT = 16,
  parameter int PRIO_W = 8,
  localparam int NUM_W = $clog2(16 + NUM_EXT)
) (
  input logic             clk,
  input logic             rstN,
  input logic             resetReq,
  input logic             nmiReq,
  input logic             memFaultReq,
  input logic             memEn,
  input logic             handlerExit,
  input logic [PRIO_W+1:0] execRank,
  input logic [NUM_W-1:0] pendNum,
  input logic [NUM_W-1:0] excNum,
  input logic             handlerMode,
  input logic             preemptStrobe
);
  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(pendNum inside {7, 8, 9, 10, 13}) && !(excNum inside {7, 8, 9, 10, 13}));

  assert_thread_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    !handlerMode |-> excNum == '0);

  assert_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    handlerExit |=> !handlerMode && !preemptStrobe);

  assert_strobe_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    preemptStrobe |-> handlerMode && excNum != '0);

  assert_reset_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> pendNum == NUM_W'(1));

  assert_nmi_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq && !resetReq |-> pendNum == NUM_W'(2));

  assert_nmi_entry_R9: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq && !resetReq && !handlerExit && (execRank > 1) &&
    !(handlerMode && (excNum == NUM_W'(1) || excNum == NUM_W'(2)))
    |=> preemptStrobe && excNum == NUM_W'(2));

  assert_escalate_R7: assert property (@(posedge clk) disable iff (!rstN)
    memFaultReq && !memEn && !resetReq && !nmiReq |-> pendNum == NUM_W'(3));
endmodule

bind exc_resolver exc_resolver_chk #(.NUM_EXT(NUM_EXT), .PRIO_W(PRIO_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .resetReq      (resetReq),
  .nmiReq        (nmiReq),
  .memFaultReq   (memFaultReq),
  .memEn         (faultEn[0]),
  .handlerExit   (handlerExit),
  .execRank      (execRank),
  .pendNum       (pendNum),
  .excNum        (excNum),
  .handlerMode   (handlerMode),
  .preemptStrobe (preemptStrobe)
);

// File: tb/tb_exc_resolver.sv
module tb_exc_resolver;
  localparam int NUM_EXT = 16;
  localparam int PRIO_W = 8;
  localparam int NUM_W = $clog2(16 + NUM_EXT);
  localparam int THREAD = (1 << PRIO_W) + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resetReq, nmiReq, hardFaultReq, memFaultReq, busFaultReq, usageFaultReq;
  logic svcReq, dbgMonReq, pendSvSet, sysTickReq, dbgMonEn, handlerExit;
  logic [NUM_EXT-1:0] extIrq, extEnable;
  logic [2:0] faultEn;
  logic [7*PRIO_W-1:0] sysPrio;
  logic [NUM_EXT*PRIO_W-1:0] extPrio;
  logic [PRIO_W+1:0] execRank;
  logic [NUM_W-1:0] pendNum, excNum;
  logic handlerMode, preemptStrobe;

  always #4 clk = ~clk;

  exc_resolver #(.NUM_EXT(NUM_EXT), .PRIO_W(PRIO_W)) dut (.*);

  typedef struct {
    bit    regPhase;
    int    due;
    string req;
    int    expPend;
    int    expNum;
    bit    expMode;
    bit    expStrobe;
  } item_t;

  item_t sbQ[$];
  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: called at a negedge with inputs already applied.
  task automatic step(string req, int ePend, int eNum, bit eMode, bit eStrobe);
    item_t it;
    it.req = req; it.expPend = ePend; it.expNum = eNum;
    it.expMode = eMode; it.expStrobe = eStrobe;
    it.regPhase = 1'b0; it.due = cyc;
    sbQ.push_back(it);
    it.regPhase = 1'b1; it.due = cyc + 1;
    sbQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic drain(bit phase);
    while (sbQ.size() > 0 && sbQ[0].due <= cyc && sbQ[0].regPhase == phase) begin
      item_t it;
      it = sbQ.pop_front();
      if (it.due < cyc) begin
        check(it.req, "missed sample", cyc, it.due);
      end else if (!phase) begin
        check(it.req, "pendNum", int'(pendNum), it.expPend);
      end else begin
        check(it.req, "excNum", int'(excNum), it.expNum);
        check(it.req, "handlerMode", int'(handlerMode), int'(it.expMode));
        check(it.req, "preemptStrobe", int'(preemptStrobe), int'(it.expStrobe));
      end
    end
  endtask

  // Monitor: combinational result before the edge, registered after it.
  initial forever begin
    @(negedge clk); #2;
    drain(1'b0);
    @(posedge clk); #2;
    drain(1'b1);
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    resetReq = 0; nmiReq = 0; hardFaultReq = 0; memFaultReq = 0; busFaultReq = 0;
    usageFaultReq = 0; svcReq = 0; dbgMonReq = 0; pendSvSet = 0; sysTickReq = 0;
    dbgMonEn = 1; handlerExit = 0; extIrq = '0; extEnable = '1; faultEn = 3'b111;
    execRank = (PRIO_W + 2)'(THREAD);
    sysPrio = {8'hE0, 8'hF0, 8'h30, 8'h80, 8'h50, 8'h40, 8'h40};
    for (int i = 0; i < NUM_EXT; i++) extPrio[i*PRIO_W +: PRIO_W] = 8'h60;
    extPrio[3*PRIO_W +: PRIO_W] = 8'h20;
    extPrio[5*PRIO_W +: PRIO_W] = 8'h20;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    step("R1 reset state", 0, 0, 0, 0);
    sysTickReq = 1;
    step("R2/R5 tick entry", 15, 15, 1, 1);
    step("R4 equal rank holds", 15, 15, 1, 0);
    pendSvSet = 1;
    step("R3 tick beats PendSV", 15, 15, 1, 0);
    extIrq[3] = 1; extIrq[5] = 1;
    step("R3 tie lower number, R4 nest", 19, 19, 1, 1);
    extIrq[3] = 0; extIrq[5] = 0; sysTickReq = 0; handlerExit = 1;
    step("R6 exit to thread", 14, 0, 0, 0);
    handlerExit = 0;
    step("R2 PendSV by software pend", 14, 14, 1, 1);
    pendSvSet = 0; extIrq[7] = 1; extEnable[7] = 0;
    step("R12 disabled line ignored", 0, 14, 1, 0);
    extIrq[7] = 0; handlerExit = 1; faultEn[0] = 0; memFaultReq = 1;
    step("R7 disabled fault shows hard fault", 3, 0, 0, 0);
    handlerExit = 0;
    step("R7 disabled fault taken as hard fault", 3, 3, 1, 1);
    memFaultReq = 0; faultEn[0] = 1; handlerExit = 1;
    step("R6 clear", 0, 0, 0, 0);
    handlerExit = 0; extIrq[3] = 1;
    step("R2 external line 3", 19, 19, 1, 1);
    busFaultReq = 1;
    step("R8 weak fault escalates", 3, 3, 1, 1);
    busFaultReq = 0; extIrq[3] = 0; handlerExit = 1;
    step("R6 clear after escalation", 0, 0, 0, 0);
    handlerExit = 0; busFaultReq = 1;
    step("R8 urgent fault keeps number", 5, 5, 1, 1);
    busFaultReq = 0; dbgMonReq = 1; execRank = 10'h020;
    step("R10 debug monitor blocked by level", 12, 5, 1, 0);
    execRank = (PRIO_W + 2)'(THREAD);
    step("R10 debug monitor enters", 12, 12, 1, 1);
    dbgMonEn = 0; handlerExit = 1;
    step("R10 disabled debug monitor", 0, 0, 0, 0);
    handlerExit = 0; dbgMonReq = 0; dbgMonEn = 1; extIrq[3] = 1;
    step("R4 enter line 3", 19, 19, 1, 1);
    nmiReq = 1; execRank = 10'h005;
    step("R9 NMI preempts through mask", 2, 2, 1, 1);
    step("R9 NMI not re-entered", 2, 2, 1, 0);
    resetReq = 1;
    step("R3 reset beats NMI", 1, 1, 1, 1);
    hardFaultReq = 1;
    step("R9 nothing preempts reset", 1, 1, 1, 0);
    resetReq = 0; nmiReq = 0; hardFaultReq = 0; extIrq[3] = 0;
    execRank = (PRIO_W + 2)'(THREAD); handlerExit = 1;
    step("R6 final clear", 0, 0, 0, 0);
    handlerExit = 0; svcReq = 1;
    step("R2/R11 SVC number", 11, 11, 1, 1);
    svcReq = 0;
    repeat (3) @(negedge clk);
    if (sbQ.size() != 0) check("R1", "scoreboard leftover", sbQ.size(), 0);
    done = 1'b1;
    finishRun();
  end
endmodule